// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block takes received Ethernet frames from a byte stream and places each one in host memory under the control of a descriptor ring. For every frame it looks at the descriptor it currently points to. If the hardware owns that descriptor, the engine copies the frame bytes into the descriptor's buffer. It then writes back a packed status word that carries the stored length, the first and last markers and a set of error bits, and it hands the descriptor back to software by clearing its ownership bit.

After the writeback the engine pulses a receive interrupt and moves to the next descriptor. The next descriptor is chosen by the end-of-ring flag, then by the chained flag, and otherwise is the following contiguous descriptor. When the current descriptor still belongs to software, the incoming frame is discarded and the loss is reported as an overflow in the next status that is written. The host sets up descriptors and reads results through a word port into the memory model held inside the block.

Each descriptor is four 32-bit words: status, control (buffer size and ring flags), buffer byte address and next-descriptor byte address. A parameter selects the normal or the extended control layout.

Top module: `rxwb_engine`

## Requirements
- R1: The engine stores into a descriptor only when bit 31 of its status word is 1. The writeback clears bit 31 and sets bit 9 (first) and bit 8 (last).
- R2: Status bits 29:16 hold the number of frame bytes stored, counting every stream byte including the trailing 4-byte FCS.
- R3: Frame byte i is written at byte address buffer+i, taken from word 2 of the descriptor. Byte address a maps to memory word a>>2, bits 8*(a%4)+7 down to 8*(a%4).
- R4: Bytes beyond the buffer size are not stored. When a frame exceeds a nonzero buffer size, the length field equals the buffer size and bit 12 (length error) is set.
- R5: A buffer size of zero stores nothing, reports length 0 and sets bit 14 (descriptor error).
- R6: The error inputs sampled with the last byte map to status bits as follows: receive error to bit 3, CRC error to bit 1, dribble to bit 2, watchdog to bit 4. Bit 15 is the OR of bits 14, 12, 11, 4, 3, 2 and 1.
- R7: A frame that starts while the current descriptor has bit 31 clear is dropped. It causes no memory write and no interrupt, and the engine stays on that descriptor. The next writeback sets bit 11 (overflow), and the writeback after that does not set it unless another frame was dropped.
- R8: The next descriptor is RING_BASE when end-of-ring is set. Otherwise it is the word-3 pointer when chained is set, and otherwise the current descriptor plus 16 bytes. In the normal layout, word 1 holds the size in bits 10:0, end-of-ring in bit 25 and chained in bit 24. In the extended layout, word 1 holds the size in bits 12:0, end-of-ring in bit 15 and chained in bit 14.
- R9: The status word is written on the clock edge after the last byte is accepted. in_ready is low for that one cycle, and rx_irq is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err_rx | input | 1 | Receive error flag, sampled with the last byte |
| in_err_crc | input | 1 | CRC error flag, sampled with the last byte |
| in_err_dribble | input | 1 | Dribble flag, sampled with the last byte |
| in_err_wdog | input | 1 | Receive watchdog flag, sampled with the last byte |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| rx_irq | output | 1 | One-cycle pulse after each writeback |
| host_we | input | 1 | Host word write enable |
| host_addr | input | AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |

## Verification
A frame byte lands in memory on the same edge that accepts it. The status word appears one edge after the last byte, and rx_irq is high during the cycle after that. The bench drives inputs and samples outputs on falling edges. It checks the interrupt on the second falling edge after the last byte is driven, and in_ready on the first. It reads memory only after both edges have passed. A sweep of frame lengths from 1 to 12 into an 8-byte buffer covers the truncation boundary, and directed frames cover the ring walk, the drop path and every error bit.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

    localparam int OWN_BIT   = 31;
    localparam int LEN_LSB   = 16;
    localparam int LEN_W     = 14;
    localparam int ES_BIT    = 15;
    localparam int DE_BIT    = 14;
    localparam int LE_BIT    = 12;
    localparam int OE_BIT    = 11;
    localparam int FIRST_BIT = 9;
    localparam int LAST_BIT  = 8;
    localparam int WDOG_BIT  = 4;
    localparam int RXE_BIT   = 3;
    localparam int DRIB_BIT  = 2;
    localparam int CRC_BIT   = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_DROP,
        ST_WB
    } rxwb_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] size;
        logic             eor;
        logic             chain;
    } rxwb_ctl_t;

    typedef struct packed {
        logic wdog;
        logic dribble;
        logic crc;
        logic rx;
    } rxwb_err_t;

    function automatic logic [31:0] rxwb_status(
        input logic [LEN_W-1:0] len,
        input logic             de,
        input logic             le,
        input logic             oe,
        input rxwb_err_t        e
    );
        logic [31:0] w;
        w = '0;
        w[LEN_LSB +: LEN_W] = len;
        w[DE_BIT]    = de;
        w[LE_BIT]    = le;
        w[OE_BIT]    = oe;
        w[FIRST_BIT] = 1'b1;
        w[LAST_BIT]  = 1'b1;
        w[WDOG_BIT]  = e.wdog;
        w[RXE_BIT]   = e.rx;
        w[DRIB_BIT]  = e.dribble;
        w[CRC_BIT]   = e.crc;
        w[ES_BIT]    = de | le | oe | e.wdog | e.rx | e.dribble | e.crc;
        return w;
    endfunction

endpackage

// File: rtl/rxwb_mem.sv
module rxwb_mem #(
    parameter int WORDS = 64,
    parameter int AW    = $clog2(WORDS),
    parameter int RD_PORTS = 4
) (
    input  logic                        clk,
    input  logic                        host_we,
    input  logic [AW-1:0]               host_addr,
    input  logic [31:0]                 host_wdata,
    output logic [31:0]                 host_rdata,
    input  logic                        eng_we,
    input  logic [3:0]                  eng_be,
    input  logic [AW-1:0]               eng_addr,
    input  logic [31:0]                 eng_wdata,
    input  logic [RD_PORTS-1:0][AW-1:0] eng_raddr,
    output logic [RD_PORTS-1:0][31:0]   eng_rdata
);

    logic [31:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (host_we && !(eng_we && eng_addr == host_addr)) begin
            store[host_addr] <= host_wdata;
        end
        if (eng_we) begin
            for (int b = 0; b < 4; b++) begin
                if (eng_be[b]) begin
                    store[eng_addr][8*b +: 8] <= eng_wdata[8*b +: 8];
                end
            end
        end
    end

    assign host_rdata = store[host_addr];

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign eng_rdata[p] = store[eng_raddr[p]];
    end

endmodule

// File: rtl/rxwb_desc_decode.sv
module rxwb_desc_decode
    import rxwb_pkg::*;
#(
    parameter bit EXT_LAYOUT = 1'b0
) (
    input  logic [31:0] ctl_word,
    output rxwb_ctl_t   ctl
);

    if (EXT_LAYOUT) begin : g_ext
        assign ctl.size  = {1'b0, ctl_word[12:0]};
        assign ctl.eor   = ctl_word[15];
        assign ctl.chain = ctl_word[14];
    end else begin : g_norm
        assign ctl.size  = {3'b000, ctl_word[10:0]};
        assign ctl.eor   = ctl_word[25];
        assign ctl.chain = ctl_word[24];
    end

endmodule

// File: rtl/rxwb_ctrl.sv
module rxwb_ctrl
    import rxwb_pkg::*;
#(
    parameter int AW        = 6,
    parameter int RING_BASE = 0,
    localparam int BW       = AW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  rxwb_err_t     in_err,
    output logic          in_ready,
    output logic          rx_irq,
    output logic [AW-1:0] cur,
    input  logic          d_own,
    input  logic [BW-1:0] d_buf,
    input  logic [AW-1:0] d_next,
    input  rxwb_ctl_t     d_ctl,
    output logic          eng_we,
    output logic [3:0]    eng_be,
    output logic [AW-1:0] eng_addr,
    output logic [31:0]   eng_wdata
);

    rxwb_state_e      st;
    logic [BW-1:0]    base;
    logic [LEN_W-1:0] size;
    logic [LEN_W-1:0] cnt;
    logic [AW-1:0]    nxt;
    rxwb_err_t        err;
    logic             ovf_pend;

    logic             acc;
    logic             start_ok;
    logic [LEN_W-1:0] off;
    logic [LEN_W-1:0] lim;
    logic [BW-1:0]    bbase;
    logic [BW-1:0]    baddr;
    logic             byte_we;
    logic             over;
    logic [LEN_W-1:0] stored;
    logic [31:0]      status;
    logic [AW-1:0]    pick_next;

    assign in_ready = (st != ST_WB);
    assign acc      = in_valid && in_ready;
    assign start_ok = (st == ST_IDLE) && d_own;

    assign off   = (st == ST_IDLE) ? '0 : cnt;
    assign lim   = (st == ST_IDLE) ? d_ctl.size : size;
    assign bbase = (st == ST_IDLE) ? d_buf : base;
    assign baddr = bbase + BW'(off);
    assign byte_we = acc && (start_ok || st == ST_RECV) && (off < lim);

    assign over   = (cnt > size);
    assign stored = over ? size : cnt;
    assign status = rxwb_status(stored, size == '0, over && size != '0, ovf_pend, err);

    always_comb begin
        if (d_ctl.eor)        pick_next = AW'(RING_BASE);
        else if (d_ctl.chain) pick_next = d_next;
        else                  pick_next = cur + AW'(4);
    end

    assign eng_we    = byte_we || (st == ST_WB);
    assign eng_be    = byte_we ? (4'b0001 << baddr[1:0]) : 4'b1111;
    assign eng_addr  = byte_we ? baddr[BW-1:2] : cur;
    assign eng_wdata = byte_we ? {4{in_data}} : status;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur      <= AW'(RING_BASE);
            base     <= '0;
            size     <= '0;
            cnt      <= '0;
            nxt      <= '0;
            err      <= '0;
            ovf_pend <= 1'b0;
            rx_irq   <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (acc) begin
                        if (d_own) begin
                            base <= d_buf;
                            size <= d_ctl.size;
                            nxt  <= pick_next;
                            cnt  <= LEN_W'(1);
                            if (in_last) begin
                                err <= in_err;
                                st  <= ST_WB;
                            end else begin
                                st  <= ST_RECV;
                            end
                        end else begin
                            ovf_pend <= 1'b1;
                            if (!in_last) st <= ST_DROP;
                        end
                    end
                end
                ST_RECV: begin
                    if (acc) begin
                        if (cnt != {LEN_W{1'b1}}) cnt <= cnt + LEN_W'(1);
                        if (in_last) begin
                            err <= in_err;
                            st  <= ST_WB;
                        end
                    end
                end
                ST_DROP: begin
                    if (acc && in_last) st <= ST_IDLE;
                end
                default: begin
                    cur      <= nxt;
                    ovf_pend <= 1'b0;
                    rx_irq   <= 1'b1;
                    st       <= ST_IDLE;
                end
            endcase
        end
    end

    p_unowned_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && in_valid && !d_own) |-> !eng_we);

    p_irq_after_wb_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WB) |=> (rx_irq && st == ST_IDLE));

    p_len_in_buf_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WB) |-> (eng_wdata[LEN_LSB +: LEN_W] <= size));

    p_release_marks_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WB) |-> (eng_we && !eng_wdata[OWN_BIT] && eng_wdata[FIRST_BIT] && eng_wdata[LAST_BIT]));

    p_summary_or_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WB) |-> (eng_wdata[ES_BIT] == |{eng_wdata[DE_BIT], eng_wdata[LE_BIT],
                                                   eng_wdata[OE_BIT], eng_wdata[WDOG_BIT:CRC_BIT]}));

    p_ovf_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WB) |=> !ovf_pend);

    p_count_rises_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RECV && $past(st) == ST_RECV) |-> (cnt >= $past(cnt)));

endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
    import rxwb_pkg::*;
#(
    parameter int MEM_WORDS  = 64,
    parameter int RING_BASE  = 0,
    parameter bit EXT_LAYOUT = 1'b0,
    localparam int AW        = $clog2(MEM_WORDS),
    localparam int BW        = AW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_err_rx,
    input  logic          in_err_crc,
    input  logic          in_err_dribble,
    input  logic          in_err_wdog,
    output logic          in_ready,
    output logic          rx_irq,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata
);

    logic [AW-1:0]         cur;
    logic [3:0][AW-1:0]    raddr;
    logic [3:0][31:0]      rdata;
    rxwb_ctl_t             ctl;
    rxwb_err_t             errs;
    logic                  eng_we;
    logic [3:0]            eng_be;
    logic [AW-1:0]         eng_addr;
    logic [31:0]           eng_wdata;

    for (genvar k = 0; k < 4; k++) begin : g_fetch
        assign raddr[k] = cur + AW'(k);
    end

    assign errs = '{wdog: in_err_wdog, dribble: in_err_dribble, crc: in_err_crc, rx: in_err_rx};

    rxwb_mem #(.WORDS(MEM_WORDS), .AW(AW), .RD_PORTS(4)) u_mem (
        .clk        (clk),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_we     (eng_we),
        .eng_be     (eng_be),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .eng_raddr  (raddr),
        .eng_rdata  (rdata)
    );

    rxwb_desc_decode #(.EXT_LAYOUT(EXT_LAYOUT)) u_dec (
        .ctl_word (rdata[1]),
        .ctl      (ctl)
    );

    rxwb_ctrl #(.AW(AW), .RING_BASE(RING_BASE)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_err    (errs),
        .in_ready  (in_ready),
        .rx_irq    (rx_irq),
        .cur       (cur),
        .d_own     (rdata[0][OWN_BIT]),
        .d_buf     (rdata[2][BW-1:0]),
        .d_next    (rdata[3][BW-1:2]),
        .d_ctl     (ctl),
        .eng_we    (eng_we),
        .eng_be    (eng_be),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata)
    );

endmodule

// File: tb/tb_rxwb_engine.sv
`timescale 1ns/1ps
module tb_rxwb_engine;

    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_last = 1'b0;
    logic in_err_rx = 1'b0, in_err_crc = 1'b0, in_err_dribble = 1'b0, in_err_wdog = 1'b0;
    logic in_ready, rx_irq;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit got_irq, rdy_wb, irq_gone;

    always #2.5 clk = ~clk;

    rxwb_engine #(.MEM_WORDS(64), .RING_BASE(0), .EXT_LAYOUT(1'b0)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_err_rx(in_err_rx), .in_err_crc(in_err_crc),
        .in_err_dribble(in_err_dribble), .in_err_wdog(in_err_wdog),
        .in_ready(in_ready), .rx_irq(rx_irq),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic hwr(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(input int a, output logic [31:0] d);
        @(negedge clk);
        host_addr = AW'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic rdbyte(input int ba, output logic [7:0] b);
        logic [31:0] w;
        hrd(ba >> 2, w);
        b = w[8*(ba % 4) +: 8];
    endtask

    // errs = {wdog, dribble, crc, rx}
    task automatic send(input int len, input int seed, input logic [3:0] errs);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'((seed + i) & 8'hff);
            in_last  = (i == len - 1);
            {in_err_wdog, in_err_dribble, in_err_crc, in_err_rx} = (i == len - 1) ? errs : 4'b0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        {in_err_wdog, in_err_dribble, in_err_crc, in_err_rx} = 4'b0;
        rdy_wb = in_ready;
        @(negedge clk);
        got_irq = rx_irq;
        @(negedge clk);
        irq_gone = !rx_irq;
    endtask

    function automatic logic [31:0] exp_st(input int len, input bit de, input bit le, input bit oe,
                                           input logic [3:0] errs);
        logic [31:0] w;
        w = '0;
        w[29:16] = 14'(len);
        w[14] = de; w[12] = le; w[11] = oe;
        w[9] = 1'b1; w[8] = 1'b1;
        w[4] = errs[3]; w[2] = errs[2]; w[1] = errs[1]; w[3] = errs[0];
        w[15] = de | le | oe | (|errs);
        return w;
    endfunction

    task automatic chk_bytes(input int ba, input int n, input int seed, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            rdbyte(ba + i, b);
            chk(b == 8'((seed + i) & 8'hff), req, {24'h0, b}, (seed + i) & 8'hff);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_irq == 1'b0, "R9 reset irq", {31'h0, rx_irq}, 0);
        chk(in_ready == 1'b1, "R9 reset ready", {31'h0, in_ready}, 1);

        for (int a = 0; a < 64; a++) hwr(a, 32'h0);
        // desc0 at word 0: size 32, chained to byte 32 (desc2)
        hwr(0, 32'h8000_0000); hwr(1, 32'd32 | (32'h1 << 24)); hwr(2, 32'd64); hwr(3, 32'd32);
        // desc2 at word 8: size 20, plain (contiguous next)
        hwr(8, 32'h8000_0000); hwr(9, 32'd20); hwr(10, 32'd128); hwr(11, 32'hFC);
        // desc3 at word 12: size 4, end of ring
        hwr(12, 32'h8000_0000); hwr(13, 32'd4 | (32'h1 << 25)); hwr(14, 32'd192); hwr(15, 32'd64);
        hwr(49, 32'hA5A5_A5A5);

        // Frame A into desc0
        send(10, 8'h10, 4'b0);
        chk(rdy_wb == 1'b0, "R9 ready low in writeback", {31'h0, rdy_wb}, 0);
        chk(got_irq == 1'b1, "R9 irq pulse", {31'h0, got_irq}, 1);
        chk(irq_gone == 1'b1, "R9 irq one cycle", {31'h0, irq_gone}, 1);
        hrd(0, w);
        chk(w == exp_st(10, 0, 0, 0, 0), "R1 R2 status A", w, exp_st(10, 0, 0, 0, 0));
        chk_bytes(64, 10, 8'h10, "R3 bytes A");

        // Frame B follows chain to desc2, CRC error
        send(5, 8'h40, 4'b0010);
        hrd(8, w);
        chk(w == exp_st(5, 0, 0, 0, 4'b0010), "R8 R6 status B chained", w, exp_st(5, 0, 0, 0, 4'b0010));
        chk_bytes(128, 5, 8'h40, "R3 bytes B");

        // Frame C to contiguous desc3, truncated
        send(7, 8'h70, 4'b0);
        hrd(12, w);
        chk(w == exp_st(4, 0, 1, 0, 0), "R4 R8 status C truncated", w, exp_st(4, 0, 1, 0, 0));
        chk_bytes(192, 4, 8'h70, "R3 bytes C");
        hrd(49, w);
        chk(w == 32'hA5A5_A5A5, "R4 no write past buffer", w, 32'hA5A5_A5A5);

        // Frame D: desc0 now software-owned -> dropped
        send(6, 8'h90, 4'b0);
        chk(got_irq == 1'b0, "R7 no irq on drop", {31'h0, got_irq}, 0);
        hrd(0, w);
        chk(w == exp_st(10, 0, 0, 0, 0), "R7 status untouched", w, exp_st(10, 0, 0, 0, 0));
        rdbyte(64, b);
        chk(b == 8'h10, "R7 buffer untouched", {24'h0, b}, 8'h10);

        // Re-arm desc0, frame E with rx, dribble, watchdog errors
        hwr(0, 32'h8000_0000);
        send(3, 8'hB0, 4'b1101);
        hrd(0, w);
        chk(w == exp_st(3, 0, 0, 1, 4'b1101), "R7 R6 R8 status E overflow", w, exp_st(3, 0, 0, 1, 4'b1101));
        chk_bytes(64, 3, 8'hB0, "R8 ring wrap bytes E");

        // desc2 re-armed with size zero
        hwr(8, 32'h8000_0000); hwr(9, 32'h0);
        send(4, 8'hC0, 4'b0);
        hrd(8, w);
        chk(w == exp_st(0, 1, 0, 0, 0), "R5 R7 status zero size", w, exp_st(0, 1, 0, 0, 0));
        rdbyte(128, b);
        chk(b == 8'h40, "R5 nothing stored", {24'h0, b}, 8'h40);

        // desc3 re-armed, exact-fit frame
        hwr(12, 32'h8000_0000); hwr(13, 32'd16 | (32'h1 << 25));
        send(16, 8'hD0, 4'b0);
        hrd(12, w);
        chk(w == exp_st(16, 0, 0, 0, 0), "R4 exact fit no length error", w, exp_st(16, 0, 0, 0, 0));
        chk_bytes(192, 16, 8'hD0, "R3 bytes F");

        // Sweep lengths against an 8-byte self-chained desc0
        for (int L = 1; L <= 12; L++) begin
            int n;
            hwr(16, 32'hEEEE_EEEE); hwr(17, 32'hEEEE_EEEE); hwr(18, 32'hEEEE_EEEE);
            hwr(0, 32'h8000_0000); hwr(1, 32'd8 | (32'h1 << 24)); hwr(2, 32'd64); hwr(3, 32'd0);
            send(L, L * 16, 4'b0);
            n = (L > 8) ? 8 : L;
            hrd(0, w);
            chk(w == exp_st(n, 0, L > 8, 0, 0), "R2 R4 sweep status", w, exp_st(n, 0, L > 8, 0, 0));
            chk_bytes(64, n, L * 16, "R3 sweep bytes");
            rdbyte(72, b);
            chk(b == 8'hEE, "R4 sweep guard byte", {24'h0, b}, 8'hEE);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule